// File: doc/BRIEF.md
# Dual-Width Compare and Step Unit

This block is the flag-and-register datapath slice of a 16-bit accumulator-style processor core. It holds three working registers (an accumulator and two index registers) and an 8-bit status register. On each cycle where the write strobe is high, it applies one operation to one register: load an operand, step it up by one, step it down by one, or compare it against an operand. It then updates the negative, zero and carry bits of the status register.

Each operation runs at a width of 8 or 16 bits. Two mode inputs set the width: one for the accumulator and one shared by both index registers. In narrow mode only the low byte of the target register is written and the high byte keeps its value. The flags then come from bit 7 instead of bit 15. Both mode inputs are copied into their status bit positions on every strobe. Instruction decode, memory access and address generation belong to the surrounding core.

Top module: `width_step_unit`

## Requirements
- R1: After a synchronous reset, all three registers read 0x0000 and the status register reads 0x34.
- R2: A cycle with the write strobe low changes no register and no status bit, whatever the other inputs carry.
- R3: Target select 0 is the accumulator and uses `acc_narrow` as its width. Selects 1 and 2 are the two index registers and share `idx_narrow`. With the width bit at 1, a result replaces only bits 7:0 and bits 15:8 keep their value.
- R4: Operation code 0 (load) writes the operand. Load, step-up and step-down set N (status bit 7) from the result's top bit, which is bit 7 when narrow and bit 15 when wide. They set Z (status bit 1) when the result at the active width is zero. They leave C (status bit 0) unchanged.
- R5: Operation code 1 adds one and code 2 subtracts one. The result wraps modulo 256 when narrow and modulo 65536 when wide.
- R6: Operation code 3 (compare) forms register minus operand at the active width with one extra borrow bit. It sets C to 1 when no borrow occurs and clears C on a borrow.
- R7: A compare sets Z when the difference at the active width is zero and copies the difference's top bit into N. It leaves every register unchanged.
- R8: On each strobe, status bit 5 takes `acc_narrow` and bit 4 takes `idx_narrow`. Status bits 6, 3 and 2 never change after reset.
- R9: Target select 3 writes no register and leaves N, Z and C unchanged. The mode bits are still captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Apply the selected operation on this edge |
| op_sel | input | 2 | 0 load, 1 step up, 2 step down, 3 compare |
| tgt_sel | input | 2 | 0 accumulator, 1 first index, 2 second index, 3 none |
| operand | input | 16 | Load value or compare operand |
| acc_narrow | input | 1 | Accumulator width: 1 = 8 bits, 0 = 16 bits |
| idx_narrow | input | 1 | Index register width: 1 = 8 bits, 0 = 16 bits |
| acc_q | output | 16 | Accumulator contents |
| xr_q | output | 16 | First index register contents |
| yr_q | output | 16 | Second index register contents |
| status_q | output | 8 | Status register (N bit 7, Z bit 1, C bit 0, widths at bits 5 and 4) |

## Verification
The bench loads a narrow zero into an accumulator whose high byte is non-zero. A design that takes Z from all 16 bits would leave Z clear, and one that clears the high byte would lose 0x12. It steps an 8-bit 0xFF and a 16-bit 0xFFFF up and steps 0x0000 down. These cases catch a carry that leaks into the kept high byte, and an N bit read from the wrong position. Compares cover equal, borrow and low-byte-equal-high-byte-different cases, which catch an inverted carry or a compare that writes its difference back. Loads after a cleared carry, strobes with no target, and idle cycles with noisy inputs expose flags or registers that move when they should hold.

// File: rtl/ws_pkg.sv
package ws_pkg;

    localparam int DATA_W = 16;

    // Status register bit positions
    localparam int ST_N  = 7;
    localparam int ST_AM = 5;
    localparam int ST_IM = 4;
    localparam int ST_Z  = 1;
    localparam int ST_C  = 0;
    localparam logic [7:0] ST_RESET = 8'h34;

    typedef enum logic [1:0] {
        OP_LOAD = 2'd0,
        OP_INC  = 2'd1,
        OP_DEC  = 2'd2,
        OP_CMP  = 2'd3
    } step_op_e;

    typedef enum logic [1:0] {
        TGT_A    = 2'd0,
        TGT_X    = 2'd1,
        TGT_Y    = 2'd2,
        TGT_NONE = 2'd3
    } tgt_e;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              n;
        logic              z;
        logic              c;
        logic              wr_reg;
    } alu_res_t;

endpackage

// File: rtl/ws_alu.sv
module ws_alu
    import ws_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  step_op_e       op,
    input  logic [W-1:0]   cur,
    input  logic [W-1:0]   opnd,
    input  logic           narrow,
    input  logic           c_in,
    output alu_res_t       res
);
    localparam int HW = W / 2;

    logic [W:0]    diff_w;
    logic [HW:0]   diff_n;
    logic [W-1:0]  full;
    logic [W-1:0]  merged;
    logic [W-1:0]  flag_src;

    always_comb begin
        diff_w = {1'b0, cur} - {1'b0, opnd};
        diff_n = {1'b0, cur[HW-1:0]} - {1'b0, opnd[HW-1:0]};

        unique case (op)
            OP_LOAD: full = opnd;
            OP_INC:  full = cur + 1'b1;
            OP_DEC:  full = cur - 1'b1;
            default: full = cur;
        endcase

        // Narrow results keep the upper half of the register
        merged = narrow ? {cur[W-1:HW], full[HW-1:0]} : full;

        if (op == OP_CMP)
            flag_src = narrow ? {{(W-HW){1'b0}}, diff_n[HW-1:0]} : diff_w[W-1:0];
        else
            flag_src = merged;

        res.value  = merged;
        res.n      = narrow ? flag_src[HW-1] : flag_src[W-1];
        res.z      = narrow ? (flag_src[HW-1:0] == '0) : (flag_src == '0);
        res.c      = (op == OP_CMP) ? ~(narrow ? diff_n[HW] : diff_w[W]) : c_in;
        res.wr_reg = (op != OP_CMP);
    end

endmodule

// File: rtl/ws_regs.sv
module ws_regs
    import ws_pkg::*;
#(
    parameter int W     = DATA_W,
    parameter int NREGS = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  tgt_e         tgt,
    input  logic [W-1:0] din,
    output logic [W-1:0] cur,
    output logic [W-1:0] a_q,
    output logic [W-1:0] x_q,
    output logic [W-1:0] y_q
);
    logic [W-1:0] bank [NREGS];

    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        localparam logic [1:0] IDX = i;
        always_ff @(posedge clk) begin
            if (rst)
                bank[i] <= '0;
            else if (we && (tgt == tgt_e'(IDX)))
                bank[i] <= din;
        end
    end

    always_comb begin
        unique case (tgt)
            TGT_A:   cur = bank[0];
            TGT_X:   cur = bank[1];
            TGT_Y:   cur = bank[2];
            default: cur = '0;
        endcase
    end

    assign a_q = bank[0];
    assign x_q = bank[1];
    assign y_q = bank[2];

endmodule

// File: rtl/width_step_unit.sv
module width_step_unit
    import ws_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [1:0]   op_sel,
    input  logic [1:0]   tgt_sel,
    input  logic [W-1:0] operand,
    input  logic         acc_narrow,
    input  logic         idx_narrow,
    output logic [W-1:0] acc_q,
    output logic [W-1:0] xr_q,
    output logic [W-1:0] yr_q,
    output logic [7:0]   status_q
);
    step_op_e     op;
    tgt_e         tgt;
    logic         narrow;
    logic [W-1:0] cur;
    alu_res_t     res;
    logic         reg_we;
    logic [7:0]   st;

    assign op     = step_op_e'(op_sel);
    assign tgt    = tgt_e'(tgt_sel);
    assign narrow = (tgt == TGT_A) ? acc_narrow : idx_narrow;
    assign reg_we = wr_en && (tgt != TGT_NONE) && res.wr_reg;

    ws_regs #(.W(W)) u_regs (
        .clk (clk),
        .rst (rst),
        .we  (reg_we),
        .tgt (tgt),
        .din (res.value),
        .cur (cur),
        .a_q (acc_q),
        .x_q (xr_q),
        .y_q (yr_q)
    );

    ws_alu #(.W(W)) u_alu (
        .op     (op),
        .cur    (cur),
        .opnd   (operand),
        .narrow (narrow),
        .c_in   (st[ST_C]),
        .res    (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_RESET;
        end else if (wr_en) begin
            st[ST_AM] <= acc_narrow;
            st[ST_IM] <= idx_narrow;
            if (tgt != TGT_NONE) begin
                st[ST_N] <= res.n;
                st[ST_Z] <= res.z;
                st[ST_C] <= res.c;
            end
        end
    end

    assign status_q = st;

    // R2: idle cycles hold everything
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(acc_q) && $stable(xr_q) && $stable(yr_q) && $stable(status_q)));

    // R3: narrow accumulator writes keep the upper byte
    a_r3_acc_high_kept: assert property (@(posedge clk) disable iff (rst)
        (wr_en && tgt_sel == 2'd0 && acc_narrow) |=> $stable(acc_q[W-1:W/2]));

    // R3: narrow index writes keep the upper byte
    a_r3_idx_high_kept: assert property (@(posedge clk) disable iff (rst)
        (wr_en && tgt_sel != 2'd0 && idx_narrow) |=> ($stable(xr_q[W-1:W/2]) && $stable(yr_q[W-1:W/2])));

    // R4: non-compare operations never move carry
    a_r4_carry_kept: assert property (@(posedge clk) disable iff (rst)
        (wr_en && op_sel != 2'd3) |=> $stable(status_q[ST_C]));

    // R7: compare leaves every register alone
    a_r7_cmp_no_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && op_sel == 2'd3) |=> ($stable(acc_q) && $stable(xr_q) && $stable(yr_q)));

    // R8: unused status bits never change
    a_r8_fixed_bits: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable({status_q[6], status_q[3], status_q[2]}));

    // R9: no-target strobe keeps registers and result flags
    a_r9_no_target: assert property (@(posedge clk) disable iff (rst)
        (wr_en && tgt_sel == 2'd3) |=> ($stable(acc_q) && $stable(xr_q) && $stable(yr_q)
                                        && $stable({status_q[ST_N], status_q[ST_Z], status_q[ST_C]})));

endmodule

// File: tb/width_step_unit_test.sv
`timescale 1ns/1ps
module width_step_unit_test;

    typedef struct {
        logic [15:0] a;
        logic [15:0] x;
        logic [15:0] y;
        logic [7:0]  st;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  op_sel = 2'd0;
    logic [1:0]  tgt_sel = 2'd0;
    logic [15:0] operand = 16'h0;
    logic        acc_narrow = 1'b1;
    logic        idx_narrow = 1'b1;
    logic [15:0] acc_q, xr_q, yr_q;
    logic [7:0]  status_q;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    exp_t q[$];

    // bench model state
    logic [15:0] m_a, m_x, m_y;
    logic [7:0]  m_st;

    always #2.5 clk = ~clk;

    width_step_unit uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .op_sel(op_sel), .tgt_sel(tgt_sel),
        .operand(operand), .acc_narrow(acc_narrow), .idx_narrow(idx_narrow),
        .acc_q(acc_q), .xr_q(xr_q), .yr_q(yr_q), .status_q(status_q)
    );

    task automatic compare(input exp_t e);
        checks++;
        if (acc_q !== e.a || xr_q !== e.x || yr_q !== e.y || status_q !== e.st) begin
            errors++;
            $display("FAIL %s: got a=%h x=%h y=%h st=%h, expected a=%h x=%h y=%h st=%h",
                     e.tag, acc_q, xr_q, yr_q, status_q, e.a, e.x, e.y, e.st);
        end
    endtask

    // Reference model of one cycle, derived from the requirements
    task automatic model(input bit we, input logic [1:0] op, input logic [1:0] tg,
                         input logic [15:0] opnd, input bit am, input bit im);
        logic [15:0] cur, res;
        logic [16:0] d;
        bit nar, n, z, c;
        if (!we) return;
        m_st[5] = am;
        m_st[4] = im;
        if (tg == 2'd3) return;
        cur = (tg == 2'd0) ? m_a : (tg == 2'd1) ? m_x : m_y;
        nar = (tg == 2'd0) ? am : im;
        c = m_st[0];
        if (op == 2'd3) begin
            if (nar) begin
                d = {9'd0, cur[7:0]} - {9'd0, opnd[7:0]};
                c = !d[8]; z = (d[7:0] == 0); n = d[7];
            end else begin
                d = {1'b0, cur} - {1'b0, opnd};
                c = !d[16]; z = (d[15:0] == 0); n = d[15];
            end
            res = cur;
        end else begin
            if (op == 2'd0)      res = opnd;
            else if (op == 2'd1) res = cur + 16'd1;
            else                 res = cur - 16'd1;
            if (nar) begin
                res = {cur[15:8], res[7:0]};
                n = res[7]; z = (res[7:0] == 0);
            end else begin
                n = res[15]; z = (res == 0);
            end
        end
        m_st[7] = n; m_st[1] = z; m_st[0] = c;
        if (tg == 2'd0) m_a = res;
        else if (tg == 2'd1) m_x = res;
        else m_y = res;
    endtask

    task automatic drive(input bit we, input logic [1:0] op, input logic [1:0] tg,
                         input logic [15:0] opnd, input bit am, input bit im, input string tag);
        exp_t e;
        @(negedge clk);
        wr_en = we; op_sel = op; tgt_sel = tg; operand = opnd;
        acc_narrow = am; idx_narrow = im;
        model(we, op, tg, opnd, am, im);
        e.a = m_a; e.x = m_x; e.y = m_y; e.st = m_st; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: one expected item per clock edge after it was queued
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) compare(q.pop_front());
        end
    end

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        exp_t r;
        m_a = 0; m_x = 0; m_y = 0; m_st = 8'h34;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        r.a = 0; r.x = 0; r.y = 0; r.st = 8'h34; r.tag = "R1 reset";
        compare(r);

        drive(1, 2'd0, 2'd0, 16'h5580, 1, 1, "R4 narrow load N");
        drive(1, 2'd0, 2'd0, 16'h1234, 0, 1, "R4 wide load");
        drive(1, 2'd0, 2'd0, 16'hAB00, 1, 1, "R3 narrow zero load keeps high");
        drive(0, 2'd1, 2'd0, 16'hFFFF, 0, 0, "R2 idle");
        drive(0, 2'd3, 2'd3, 16'h0001, 1, 0, "R2 idle noisy");
        drive(1, 2'd0, 2'd1, 16'hFFFF, 1, 0, "R3 index wide load");
        drive(1, 2'd1, 2'd1, 16'h0000, 1, 1, "R5 narrow inc wrap");
        drive(1, 2'd0, 2'd1, 16'hFFFF, 1, 0, "R4 reload");
        drive(1, 2'd1, 2'd1, 16'h0000, 1, 0, "R5 wide inc wrap");
        drive(1, 2'd2, 2'd2, 16'h0000, 1, 1, "R5 narrow dec wrap");
        drive(1, 2'd2, 2'd2, 16'h0000, 1, 0, "R5 wide dec");
        drive(1, 2'd0, 2'd2, 16'h0000, 1, 0, "R4 clear");
        drive(1, 2'd2, 2'd2, 16'h0000, 1, 0, "R5 wide dec wrap");
        drive(1, 2'd0, 2'd0, 16'h1200, 0, 1, "R4 acc set");
        drive(1, 2'd3, 2'd0, 16'h1200, 0, 1, "R6 cmp equal");
        drive(1, 2'd3, 2'd0, 16'h1201, 0, 1, "R6 cmp borrow");
        drive(1, 2'd0, 2'd0, 16'h0042, 0, 1, "R4 load keeps C");
        drive(1, 2'd3, 2'd0, 16'h3342, 1, 1, "R7 narrow cmp low equal");
        drive(1, 2'd3, 2'd0, 16'h0043, 1, 1, "R6 narrow cmp borrow");
        drive(1, 2'd3, 2'd1, 16'h8000, 1, 0, "R7 wide cmp N");
        drive(1, 2'd0, 2'd3, 16'h0000, 0, 0, "R9 no target");
        drive(1, 2'd1, 2'd3, 16'h0000, 1, 1, "R8 mode capture");
        for (int i = 0; i < 300; i++)
            drive($urandom_range(0, 3) != 0, 2'($urandom), 2'($urandom), 16'($urandom),
                  1'($urandom), 1'($urandom), "R3 mixed");
        drive(0, 2'd0, 2'd0, 16'h0, 1, 1, "R2 tail");
        repeat (3) @(posedge clk);
        #1;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule